// File: doc/BRIEF.md
# Multi-mode GPIO controller with edge and level interrupts

This block is a general-purpose I/O controller for a row of pads, one bit per pin in every register, reached over a simple word-wide register bus. The bus has an address, a write strobe, write data and read data. The controller keeps per-pin settings for input gating, output enable and the output value. It can hand any pin's output to one of two hardware functions. A final inversion stage sits on every output. Pull-up and drive-strength settings are only held and exported to the pad ring.

Every pin can flag four separate conditions: a rising edge, a falling edge, a high level and a low level. Each condition has its own enable register and its own pending register. Pending bits are cleared by writing ones, and a per-pin interrupt line goes high when any enabled condition is pending. Pad inputs pass through a two-flop synchroniser before anything looks at them.

Top module: `gpio_ctrl`

## Requirements
- R1: During and just after reset, pad_out, pad_oe and irq are 0, and every register reads 0. The only exception is the low-level pending register, which begins setting from the first cycle for pins that are low.
- R2: Word registers are decoded from bus_addr[6:2], and only when bus_addr[1:0] is 0. The read/write registers sit at these byte offsets: 0x04 input gate, 0x08 output enable, 0x0C port value, 0x10 pull-up, 0x14 drive, 0x18/0x20/0x28/0x30 enables for rise/fall/high/low, 0x38 function enable, 0x3C function select, 0x40 inversion. Each reads back what was written. bus_rdata is registered and shows the register addressed at the previous clock edge. An unmapped offset reads 0, and a misaligned access reads 0 and writes nothing.
- R3: Offset 0x00 reads the synchronised pad inputs ANDed with the input-gate register, two clocks of synchroniser delay. Writes to it have no effect.
- R4: pad_out is registered one cycle from src XOR inversion[i]. src is fn0_out[i] when function enable is set and function select is 0, fn1_out[i] when both are set, and the port bit otherwise. pad_oe equals the output-enable register.
- R5: pad_pullup and pad_drive equal the pull-up and drive registers and affect nothing else.
- R6: Rise pending (0x1C) and fall pending (0x24) set on a 0-to-1 or 1-to-0 change of the synchronised input. This happens whatever the input gate holds.
- R7: High pending (0x2C) and low pending (0x34) set on every cycle that the synchronised input is 1 or 0, respectively.
- R8: Writing a pending register clears the bits written as 1 and leaves the bits written as 0.
- R9: When a set event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R10: irq[i] is registered one cycle from the OR, over the four conditions, of pending[i] AND enable[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad inputs |
| fn0_out | input | 32 | Output values of hardware function 0 |
| fn1_out | input | 32 | Output values of hardware function 1 |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Pad output enables |
| pad_pullup | output | 32 | Pull-up enables to the pads |
| pad_drive | output | 32 | Drive-strength selects to the pads |
| irq | output | 32 | Per-pin interrupt lines |

## Verification
The hardest case to reach from the ports is a clearing write that lands on exactly the clock edge where an edge event sets the same pending bit. The event passes through three registers after the pad changes, so the bench changes one pad at a falling clock edge. It then places the write strobe so that the write is sampled on the third rising edge, and expects the bit to survive. A second clear one cycle later must then remove it. Level conditions show the same priority every time a held level is cleared. Random register writes, pad patterns and partial clear masks are checked against a bench model of every register, the pad outputs and the interrupt lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word index of each register (byte offset / 4); software decodes these
  localparam int IDX_VALUE   = 0;
  localparam int IDX_IGATE   = 1;
  localparam int IDX_OENA    = 2;
  localparam int IDX_PORT    = 3;
  localparam int IDX_PULL    = 4;
  localparam int IDX_DRIVE   = 5;
  localparam int IDX_COND0   = 6;   // first condition enable; pending follows
  localparam int IDX_FN_EN   = 14;
  localparam int IDX_FN_SEL  = 15;
  localparam int IDX_INVERT  = 16;
  localparam int NCOND       = 4;

  typedef enum logic [1:0] {
    COND_RISE = 2'd0,
    COND_FALL = 2'd1,
    COND_HIGH = 2'd2,
    COND_LOW  = 2'd3
  } cond_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] raw,
  output logic [NPIN-1:0] level,
  output logic [NPIN-1:0] rose,
  output logic [NPIN-1:0] fell
);
  logic [NPIN-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rose  = sync_q & ~prev_q;
  assign fell  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_irq_cond.sv
module gpio_irq_cond #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_we,
  input  logic            clr_we,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] set,
  output logic [NPIN-1:0] enable,
  output logic [NPIN-1:0] pend
);
  logic [NPIN-1:0] clr_mask;

  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      pend   <= '0;
    end else begin
      if (en_we) enable <= wdata;
      pend <= (pend & ~clr_mask) | set;
    end
  end

  // R9: an event in a cycle always leaves its bit set, clear or not
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(set)) == $past(set)));

  // R8: a cleared bit with no event is gone next cycle
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past((clr_we ? wdata : '0) & ~set)) == '0));

  // R6: a pending bit only rises because of an event
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(set)) == '0));
endmodule

// File: rtl/gpio_out_path.sv
module gpio_out_path #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] port,
  input  logic [NPIN-1:0] fn_en,
  input  logic [NPIN-1:0] fn_sel,
  input  logic [NPIN-1:0] invert,
  input  logic [NPIN-1:0] fn0,
  input  logic [NPIN-1:0] fn1,
  output logic [NPIN-1:0] pad_out
);
  logic [NPIN-1:0] src;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      if (!fn_en[i])      src[i] = port[i];
      else if (fn_sel[i]) src[i] = fn1[i];
      else                src[i] = fn0[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pad_out <= '0;
    else     pad_out <= src ^ invert;
  end

  // R4: with no override and no inversion the pad follows the port register
  a_r4_port_path: assert property (@(posedge clk) disable iff (rst)
    (fn_en == '0 && invert == '0) |=> (pad_out == $past(port)));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [NPIN-1:0]   fn0_out,
  input  logic [NPIN-1:0]   fn1_out,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pullup,
  output logic [NPIN-1:0]   pad_drive,
  output logic [NPIN-1:0]   irq
);
  import gpio_pkg::*;

  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]   reg_idx;
  logic            aligned, wr_hit;
  logic [NPIN-1:0] igate_q, oena_q, port_q, pull_q, drive_q;
  logic [NPIN-1:0] fn_en_q, fn_sel_q, invert_q;
  logic [NPIN-1:0] in_level, in_rose, in_fell;
  logic [NPIN-1:0] c_set [NCOND];
  logic [NPIN-1:0] c_en  [NCOND];
  logic [NPIN-1:0] c_pd  [NCOND];
  logic [NPIN-1:0] irq_any, any_en, rd_mux;

  assign reg_idx = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_hit  = bus_we & aligned;

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst(rst), .raw(pad_in),
    .level(in_level), .rose(in_rose), .fell(in_fell)
  );

  for (genvar c = 0; c < NCOND; c++) begin : g_cond
    if (c == int'(COND_RISE))      begin : g_r assign c_set[c] = in_rose;   end
    else if (c == int'(COND_FALL)) begin : g_f assign c_set[c] = in_fell;   end
    else if (c == int'(COND_HIGH)) begin : g_h assign c_set[c] = in_level;  end
    else                           begin : g_l assign c_set[c] = ~in_level; end

    gpio_irq_cond #(.NPIN(NPIN)) u_cond (
      .clk(clk), .rst(rst),
      .en_we (wr_hit && reg_idx == IW'(IDX_COND0 + 2*c)),
      .clr_we(wr_hit && reg_idx == IW'(IDX_COND0 + 2*c + 1)),
      .wdata(bus_wdata), .set(c_set[c]),
      .enable(c_en[c]), .pend(c_pd[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      igate_q  <= '0;
      oena_q   <= '0;
      port_q   <= '0;
      pull_q   <= '0;
      drive_q  <= '0;
      fn_en_q  <= '0;
      fn_sel_q <= '0;
      invert_q <= '0;
    end else if (wr_hit) begin
      case (reg_idx)
        IW'(IDX_IGATE):  igate_q  <= bus_wdata;
        IW'(IDX_OENA):   oena_q   <= bus_wdata;
        IW'(IDX_PORT):   port_q   <= bus_wdata;
        IW'(IDX_PULL):   pull_q   <= bus_wdata;
        IW'(IDX_DRIVE):  drive_q  <= bus_wdata;
        IW'(IDX_FN_EN):  fn_en_q  <= bus_wdata;
        IW'(IDX_FN_SEL): fn_sel_q <= bus_wdata;
        IW'(IDX_INVERT): invert_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_out_path #(.NPIN(NPIN)) u_out (
    .clk(clk), .rst(rst), .port(port_q), .fn_en(fn_en_q), .fn_sel(fn_sel_q),
    .invert(invert_q), .fn0(fn0_out), .fn1(fn1_out), .pad_out(pad_out)
  );

  assign pad_oe     = oena_q;
  assign pad_pullup = pull_q;
  assign pad_drive  = drive_q;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (reg_idx)
        IW'(IDX_VALUE):     rd_mux = in_level & igate_q;
        IW'(IDX_IGATE):     rd_mux = igate_q;
        IW'(IDX_OENA):      rd_mux = oena_q;
        IW'(IDX_PORT):      rd_mux = port_q;
        IW'(IDX_PULL):      rd_mux = pull_q;
        IW'(IDX_DRIVE):     rd_mux = drive_q;
        IW'(IDX_COND0):     rd_mux = c_en[0];
        IW'(IDX_COND0 + 1): rd_mux = c_pd[0];
        IW'(IDX_COND0 + 2): rd_mux = c_en[1];
        IW'(IDX_COND0 + 3): rd_mux = c_pd[1];
        IW'(IDX_COND0 + 4): rd_mux = c_en[2];
        IW'(IDX_COND0 + 5): rd_mux = c_pd[2];
        IW'(IDX_COND0 + 6): rd_mux = c_en[3];
        IW'(IDX_COND0 + 7): rd_mux = c_pd[3];
        IW'(IDX_FN_EN):     rd_mux = fn_en_q;
        IW'(IDX_FN_SEL):    rd_mux = fn_sel_q;
        IW'(IDX_INVERT):    rd_mux = invert_q;
        default:            rd_mux = '0;
      endcase
    end
  end

  always_comb begin
    irq_any = '0;
    any_en  = '0;
    for (int c = 0; c < NCOND; c++) begin
      irq_any = irq_any | (c_en[c] & c_pd[c]);
      any_en  = any_en | c_en[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      bus_rdata <= rd_mux;
      irq       <= irq_any;
    end
  end

  // R10: a pin with no enabled condition never raises its line
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq & ~$past(any_en)) == '0));

  // R3: the value register never shows a pin whose input gate is off
  a_r3_value_gated: assert property (@(posedge clk) disable iff (rst)
    (aligned && reg_idx == IW'(IDX_VALUE)) |=> ((bus_rdata & ~$past(igate_q)) == '0));
endmodule

// File: tb/gpio_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, fn0 = '0, fn1 = '0;
  logic [31:0] pad_out, pad_oe, pad_pullup, pad_drive, irq;

  always #2 clk = ~clk;

  gpio_ctrl u_gpio_ctrl (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pad_in(pin_in), .fn0_out(fn0), .fn1_out(fn1),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup),
    .pad_drive(pad_drive), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_igate = '0, m_oena = '0, m_port = '0, m_pull = '0, m_drive = '0;
  logic [31:0] m_fen = '0, m_fsel = '0, m_inv = '0, cur = '0;
  logic [31:0] m_en [4];
  logic [31:0] m_pd [4];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_out();
    return ((m_fen & ((m_fsel & fn1) | (~m_fsel & fn0))) | (~m_fen & m_port)) ^ m_inv;
  endfunction

  function automatic logic [31:0] exp_irq();
    logic [31:0] r = '0;
    for (int c = 0; c < 4; c++) r = r | (m_en[c] & m_pd[c]);
    return r;
  endfunction

  function automatic logic [6:0] rw_addr(input int k);
    case (k)
      0: return 7'h04;  1: return 7'h08;  2: return 7'h0C;  3: return 7'h10;
      4: return 7'h14;  5: return 7'h18;  6: return 7'h20;  7: return 7'h28;
      8: return 7'h30;  9: return 7'h38;  10: return 7'h3C; default: return 7'h40;
    endcase
  endfunction

  task automatic model_write(input logic [6:0] a, input logic [31:0] d);
    case (a)
      7'h04: m_igate = d;  7'h08: m_oena = d;  7'h0C: m_port = d;
      7'h10: m_pull = d;   7'h14: m_drive = d; 7'h18: m_en[0] = d;
      7'h20: m_en[1] = d;  7'h28: m_en[2] = d; 7'h30: m_en[3] = d;
      7'h38: m_fen = d;    7'h3C: m_fsel = d;  7'h40: m_inv = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [6:0] a);
    case (a)
      7'h04: return m_igate; 7'h08: return m_oena;  7'h0C: return m_port;
      7'h10: return m_pull;  7'h14: return m_drive; 7'h18: return m_en[0];
      7'h20: return m_en[1]; 7'h28: return m_en[2]; 7'h30: return m_en[3];
      7'h38: return m_fen;   7'h3C: return m_fsel;  default: return m_inv;
    endcase
  endfunction

  task automatic write_rw(input logic [6:0] a, input logic [31:0] d);
    wr(a, d);
    model_write(a, d);
    settle();
  endtask

  task automatic set_pins(input logic [31:0] v, input logic [31:0] f0, input logic [31:0] f1);
    m_pd[0] = m_pd[0] | (v & ~cur);
    m_pd[1] = m_pd[1] | (~v & cur);
    m_pd[2] = m_pd[2] | v;
    m_pd[3] = m_pd[3] | ~v;
    cur = v;
    @(negedge clk); pin_in = v; fn0 = f0; fn1 = f1;
    settle();
  endtask

  task automatic clear_pd(input int c, input logic [31:0] mask);
    wr(7'h1C + 7'(8 * c), mask);
    m_pd[c] = m_pd[c] & ~mask;
    if (c == 2) m_pd[2] = m_pd[2] | cur;
    if (c == 3) m_pd[3] = m_pd[3] | ~cur;
    settle();
  endtask

  task automatic check_all();
    logic [31:0] d;
    rd(7'h00, d);  check("R3 value", d, cur & m_igate);
    rd(7'h1C, d);  check("R6 rise pending", d, m_pd[0]);
    rd(7'h24, d);  check("R6 fall pending", d, m_pd[1]);
    rd(7'h2C, d);  check("R7 high pending", d, m_pd[2]);
    rd(7'h34, d);  check("R7 low pending", d, m_pd[3]);
    check("R4 pad_out", pad_out, exp_out());
    check("R4 pad_oe", pad_oe, m_oena);
    check("R5 pullup", pad_pullup, m_pull);
    check("R5 drive", pad_drive, m_drive);
    check("R10 irq", irq, exp_irq());
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, s;
    for (int c = 0; c < 4; c++) begin m_en[c] = '0; m_pd[c] = '0; end
    s = $urandom(32'h5eed_0042);
    repeat (5) @(negedge clk);
    check("R1 pad_out in reset", pad_out, 32'h0);
    check("R1 pad_oe in reset", pad_oe, 32'h0);
    check("R1 irq in reset", irq, 32'h0);
    rst = 1'b0;
    m_pd[3] = 32'hFFFF_FFFF;
    for (int k = 0; k < 12; k++) begin
      rd(rw_addr(k), d);
      check("R1 register after reset", d, 32'h0);
    end
    rd(7'h1C, d); check("R1 rise pending after reset", d, 32'h0);
    rd(7'h2C, d); check("R1 high pending after reset", d, 32'h0);
    rd(7'h34, d); check("R7 low pending with pins low", d, 32'hFFFF_FFFF);

    // R2 readback of every read/write register
    for (int k = 0; k < 12; k++) begin
      write_rw(rw_addr(k), 32'hA5C3_0F5A ^ (32'h0101_0101 * k));
      rd(rw_addr(k), d);
      check("R2 readback", d, model_read(rw_addr(k)));
    end
    rd(7'h44, d); check("R2 unmapped 0x44", d, 32'h0);
    rd(7'h7C, d); check("R2 unmapped 0x7C", d, 32'h0);
    rd(7'h05, d); check("R2 misaligned read", d, 32'h0);
    wr(7'h05, 32'hFFFF_FFFF);
    rd(7'h04, d); check("R2 misaligned write ignored", d, m_igate);
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h00, d); check("R3 value write ignored", d, cur & m_igate);
    check_all();

    // R8 partial clear on an edge condition
    set_pins(32'h0000_FFFF, 32'h0, 32'h0);
    clear_pd(0, 32'h0000_00FF);
    rd(7'h1C, d); check("R8 partial clear of rise", d, 32'h0000_FF00);
    clear_pd(0, 32'hFFFF_FFFF);
    rd(7'h1C, d); check("R8 full clear of rise", d, 32'h0);

    // R9 clearing write lands on the edge that sets rise pending for pin 16
    @(negedge clk); pin_in = 32'h0001_FFFF;
    @(negedge clk);
    wr(7'h1C, 32'h0001_0000);
    m_pd[0] = m_pd[0] | 32'h0001_0000;
    m_pd[2] = m_pd[2] | 32'h0001_FFFF;
    m_pd[3] = m_pd[3] | 32'hFFFE_0000;
    cur = 32'h0001_FFFF;
    settle();
    rd(7'h1C, d); check("R9 edge set beats clear", d, 32'h0001_0000);
    clear_pd(0, 32'h0001_0000);
    rd(7'h1C, d); check("R8 later clear removes it", d, 32'h0);
    clear_pd(2, 32'hFFFF_FFFF);
    rd(7'h2C, d); check("R9 held high beats clear", d, cur);
    check_all();

    // random mix
    for (int it = 0; it < 90; it++) begin
      case ($urandom % 3)
        0: set_pins($urandom, $urandom, $urandom);
        1: write_rw(rw_addr(int'($urandom % 12)), $urandom);
        default: clear_pd(int'($urandom % 4), $urandom);
      endcase
      check_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule